// File: doc/BRIEF.md
# Double-Word Stack Arithmetic Unit

This unit carries out 32-bit arithmetic and comparison for a stack machine whose stack entries are 16 bits wide. A caller presents the four top stack words and an operation code, then pulses a start strobe. The left operand is the pair word1:word0 and the right operand is the pair word3:word2, with the high half in the odd word. The unit copies the four words on the start edge. It works through the low halves and then the high halves with one shared 16-bit adder, passing the carry (or the inverted borrow) from the first pass to the second.

At the end it raises a one-cycle completion pulse. With that pulse it presents the words to write back, a write enable for each word, and the amount by which the caller must lower its stack pointer. Add and subtract write a 32-bit result and drop two words. The two compares write a single word holding -1, 0 or +1 and drop three words. The signed compare uses the unsigned subtract path after it inverts the sign bit of both high words. An unknown operation code finishes at once and changes nothing.

Top module: `dw_stack_alu`

## Requirements
- R1: After reset, `done`, `res_lo_we`, `res_hi_we` and `sp_dec` are 0, and `res_lo` and `res_hi` are 0.
- R2: With `op_sel` = 0 (add), the result {res_hi,res_lo} equals ({stk1,stk0} + {stk3,stk2}) mod 2^32. Both write enables are 1 and `sp_dec` = 2.
- R3: In add, the carry out of the low-word sum is added into the high-word sum. For example, 0x0000FFFF + 0x00000001 gives 0x00010000.
- R4: With `op_sel` = 1 (subtract), the result equals ({stk1,stk0} - {stk3,stk2}) mod 2^32, and a borrow from the low words lowers the high difference by one. Both write enables are 1 and `sp_dec` = 2.
- R5: With `op_sel` = 2 (signed compare), the operands are compared as two's-complement 32-bit values. `res_lo` is 0xFFFF when left < right, 0x0000 when they are equal and 0x0001 when left > right. `res_lo_we` = 1, `res_hi_we` = 0 and `sp_dec` = 3.
- R6: With `op_sel` = 3 (unsigned compare), the same encoding, write enables and `sp_dec` = 3 apply, with the operands compared as unsigned 32-bit values.
- R7: With `op_sel` from 4 to 7, `done` rises in the first cycle after the start edge. Both write enables are 0 and `sp_dec` = 0, so the stack stays unchanged.
- R8: For a defined operation, `done` is high only in the third cycle after the start edge, and it is high for exactly one cycle.
- R9: The operation code and the operands are taken only on the start edge while the unit is idle. Start pulses during an operation, and changes to `stk0`..`stk3` after the start edge, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_sel | input | 3 | 0 add, 1 subtract, 2 signed compare, 3 unsigned compare |
| stk0 | input | 16 | Left operand, low word |
| stk1 | input | 16 | Left operand, high word |
| stk2 | input | 16 | Right operand, low word |
| stk3 | input | 16 | Right operand, high word |
| res_lo | output | 16 | Word to write back at stack word 0 |
| res_hi | output | 16 | Word to write back at stack word 1 |
| res_lo_we | output | 1 | Write enable for res_lo, valid with done |
| res_hi_we | output | 1 | Write enable for res_hi, valid with done |
| sp_dec | output | 2 | Stack pointer decrement, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong carry or borrow latched between the two passes affects only the high result word. It shows up in the completion cycle as an off-by-one in `res_hi`, or as a compare that answers less-than instead of greater-than or equal. Operands built so that the low halves overflow or underflow exercise this case. If the bias inversion is lost, the signed compare gives the wrong answer for every pair whose sign bits differ, such as 0x80000000 against 0x7FFFFFFF. A sequencer that skips or repeats a state moves `done` away from the third cycle, and that shows in the same operation.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

  localparam int OP_W  = 3;
  localparam int SPD_W = 2;

  localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB  = 3'd1;
  localparam logic [OP_W-1:0] OP_SCMP = 3'd2;
  localparam logic [OP_W-1:0] OP_UCMP = 3'd3;

  localparam logic [SPD_W-1:0] SPD_ARITH = 2'd2;
  localparam logic [SPD_W-1:0] SPD_CMP   = 2'd3;
  localparam logic [SPD_W-1:0] SPD_NONE  = 2'd0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } dw_state_e;

  typedef struct packed {
    logic valid;
    logic is_sub;
    logic is_cmp;
    logic is_signed;
  } dw_opdec_t;

  function automatic dw_opdec_t dw_decode(input logic [OP_W-1:0] op);
    dw_opdec_t d;
    d = '0;
    case (op)
      OP_ADD:  d.valid = 1'b1;
      OP_SUB:  begin d.valid = 1'b1; d.is_sub = 1'b1; end
      OP_SCMP: begin d.valid = 1'b1; d.is_sub = 1'b1; d.is_cmp = 1'b1; d.is_signed = 1'b1; end
      OP_UCMP: begin d.valid = 1'b1; d.is_sub = 1'b1; d.is_cmp = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dwalu_half_alu.sv
module dwalu_half_alu #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  output logic [WORD_W-1:0] sum,
  output logic              cout
);
  localparam int EXT_W = WORD_W + 1;

  logic [WORD_W-1:0] b_eff;
  logic [EXT_W-1:0]  total;

  always_comb begin
    b_eff = sub ? ~b : b;
    total = {1'b0, a} + {1'b0, b_eff} + {{WORD_W{1'b0}}, cin};
    sum   = total[WORD_W-1:0];
    cout  = total[WORD_W];
  end
endmodule

// File: rtl/dwalu_seq.sv
module dwalu_seq
  import dwalu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      op_valid,
  output dw_state_e state,
  output logic      cap_en,
  output logic      lo_en,
  output logic      hi_en,
  output logic      busy,
  output logic      done
);
  dw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = op_valid ? ST_LOW : ST_DONE;
      ST_LOW:  state_d = ST_HIGH;
      ST_HIGH: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state  = state_q;
  assign cap_en = (state_q == ST_IDLE) && start;
  assign lo_en  = (state_q == ST_LOW);
  assign hi_en  = (state_q == ST_HIGH);
  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_DONE);
endmodule

// File: rtl/dwalu_result.sv
module dwalu_result
  import dwalu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  dw_opdec_t         dec,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic              hi_carry,
  output logic [WORD_W-1:0] out_lo,
  output logic [WORD_W-1:0] out_hi,
  output logic              we_lo,
  output logic              we_hi,
  output logic [SPD_W-1:0]  spd
);
  localparam logic [WORD_W-1:0] ONE_W = {{(WORD_W-1){1'b0}}, 1'b1};

  logic borrow;
  logic is_zero;

  always_comb begin
    borrow  = ~hi_carry;
    is_zero = ((lo_word | hi_word) == '0);
    out_lo  = lo_word;
    out_hi  = hi_word;
    we_lo   = 1'b0;
    we_hi   = 1'b0;
    spd     = SPD_NONE;
    if (dec.valid) begin
      if (dec.is_cmp) begin
        out_hi = '0;
        we_lo  = 1'b1;
        spd    = SPD_CMP;
        if (borrow)       out_lo = '1;
        else if (is_zero) out_lo = '0;
        else              out_lo = ONE_W;
      end else begin
        we_lo = 1'b1;
        we_hi = 1'b1;
        spd   = SPD_ARITH;
      end
    end
  end
endmodule

// File: rtl/dw_stack_alu.sv
module dw_stack_alu
  import dwalu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [WORD_W-1:0] stk0,
  input  logic [WORD_W-1:0] stk1,
  input  logic [WORD_W-1:0] stk2,
  input  logic [WORD_W-1:0] stk3,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi,
  output logic              res_lo_we,
  output logic              res_hi_we,
  output logic [SPD_W-1:0]  sp_dec,
  output logic              done
);
  localparam int NWORDS = 4;
  localparam logic [WORD_W-1:0] SIGN_BIAS = {1'b1, {(WORD_W-1){1'b0}}};

  dw_state_e state;
  logic      cap_en, lo_en, hi_en, busy;

  dw_opdec_t dec_in, dec_q;
  logic [WORD_W-1:0] stk_in [NWORDS];
  logic [WORD_W-1:0] opnd   [NWORDS];

  logic [WORD_W-1:0] alu_a, alu_b, alu_sum, bias;
  logic              alu_cin, alu_cout;
  logic [WORD_W-1:0] lo_q;
  logic              carry_q;

  logic [WORD_W-1:0] fin_lo, fin_hi;
  logic              fin_we_lo, fin_we_hi;
  logic [SPD_W-1:0]  fin_spd;

  logic [WORD_W-1:0] res_lo_d, res_hi_d;
  logic              res_lo_we_d, res_hi_we_d;
  logic [SPD_W-1:0]  sp_dec_d;

  assign dec_in    = dw_decode(op_sel);
  assign stk_in[0] = stk0;
  assign stk_in[1] = stk1;
  assign stk_in[2] = stk2;
  assign stk_in[3] = stk3;

  dwalu_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_valid (dec_in.valid),
    .state    (state),
    .cap_en   (cap_en),
    .lo_en    (lo_en),
    .hi_en    (hi_en),
    .busy     (busy),
    .done     (done)
  );

  // operand capture, one register per stack word
  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_opnd
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= '0;
      else if (cap_en) word_q <= stk_in[gi];
    end
    assign opnd[gi] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dec_q <= '0;
    else if (cap_en) dec_q <= dec_in;
  end

  // operand steering into the shared half-width adder
  always_comb begin
    bias = dec_q.is_signed ? SIGN_BIAS : '0;
    if (state == ST_HIGH) begin
      alu_a   = opnd[1] ^ bias;
      alu_b   = opnd[3] ^ bias;
      alu_cin = carry_q;
    end else begin
      alu_a   = opnd[0];
      alu_b   = opnd[2];
      alu_cin = dec_q.is_sub;
    end
  end

  dwalu_half_alu #(.WORD_W(WORD_W)) u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .sub  (dec_q.is_sub),
    .cin  (alu_cin),
    .sum  (alu_sum),
    .cout (alu_cout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      carry_q <= 1'b0;
    end else if (lo_en) begin
      lo_q    <= alu_sum;
      carry_q <= alu_cout;
    end
  end

  dwalu_result #(.WORD_W(WORD_W)) u_res (
    .dec      (dec_q),
    .lo_word  (lo_q),
    .hi_word  (alu_sum),
    .hi_carry (alu_cout),
    .out_lo   (fin_lo),
    .out_hi   (fin_hi),
    .we_lo    (fin_we_lo),
    .we_hi    (fin_we_hi),
    .spd      (fin_spd)
  );

  always_comb begin
    res_lo_d    = res_lo;
    res_hi_d    = res_hi;
    res_lo_we_d = res_lo_we;
    res_hi_we_d = res_hi_we;
    sp_dec_d    = sp_dec;
    if (hi_en) begin
      res_lo_d    = fin_lo;
      res_hi_d    = fin_hi;
      res_lo_we_d = fin_we_lo;
      res_hi_we_d = fin_we_hi;
      sp_dec_d    = fin_spd;
    end else if (cap_en && !dec_in.valid) begin
      res_lo_we_d = 1'b0;
      res_hi_we_d = 1'b0;
      sp_dec_d    = SPD_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo    <= '0;
      res_hi    <= '0;
      res_lo_we <= 1'b0;
      res_hi_we <= 1'b0;
      sp_dec    <= SPD_NONE;
    end else begin
      res_lo    <= res_lo_d;
      res_hi    <= res_hi_d;
      res_lo_we <= res_lo_we_d;
      res_hi_we <= res_hi_we_d;
      sp_dec    <= sp_dec_d;
    end
  end
endmodule

// File: rtl/dwalu_chk.sv
module dwalu_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        op_sel,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] res_lo,
  input logic              res_lo_we,
  input logic              res_hi_we,
  input logic [1:0]        sp_dec
);
  localparam logic [WORD_W-1:0] ONE_W = {{(WORD_W-1){1'b0}}, 1'b1};

  // R8
  def_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_sel[2]) |-> ##3 done);

  // R8
  def_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_sel[2]) |=> !done);

  // R8
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R7
  undef_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_sel[2]) |=> (done && !res_lo_we && !res_hi_we && sp_dec == 2'd0));

  // R5
  cmp_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sp_dec == 2'd3) |-> (res_lo_we && !res_hi_we &&
      (res_lo == '0 || res_lo == '1 || res_lo == ONE_W)));

  // R2
  arith_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_hi_we) |-> (res_lo_we && sp_dec == 2'd2));
endmodule

bind dw_stack_alu dwalu_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .op_sel    (op_sel),
  .busy      (busy),
  .done      (done),
  .res_lo    (res_lo),
  .res_lo_we (res_lo_we),
  .res_hi_we (res_hi_we),
  .sp_dec    (sp_dec)
);

// File: tb/dw_stack_alu_tb.sv
`timescale 1ns/1ps
module dw_stack_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [15:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0;
  logic [15:0] res_lo, res_hi;
  logic        res_lo_we, res_hi_we, done;
  logic [1:0]  sp_dec;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dw_stack_alu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .stk0(s0), .stk1(s1), .stk2(s2), .stk3(s3),
    .res_lo(res_lo), .res_hi(res_hi), .res_lo_we(res_lo_we),
    .res_hi_we(res_hi_we), .sp_dec(sp_dec), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cmp_word(input logic [31:0] l, input logic [31:0] r, input bit sgn);
    bit lt;
    lt = sgn ? ($signed(l) < $signed(r)) : (l < r);
    if (lt) return 16'hFFFF;
    if (l == r) return 16'h0000;
    return 16'h0001;
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2/R3 add";
      3'd1: return "R4 sub";
      3'd2: return "R5 scmp";
      3'd3: return "R6 ucmp";
      default: return "R7 undef";
    endcase
  endfunction

  // one operation; disturb drives a second start while busy (R9)
  task automatic apply(input logic [2:0] op, input logic [31:0] l, input logic [31:0] r, input bit disturb);
    string rq;
    logic [31:0] exp_res;
    rq = req_of(op);
    @(negedge clk);
    op_sel = op; {s1, s0} = l; {s3, s2} = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    {s1, s0} = ~l; {s3, s2} = l ^ 32'h5A5A_A5A5;
    if (op[2]) begin
      chk({rq, " done"}, {31'd0, done}, 32'd1);
      chk({rq, " we/spd"}, {28'd0, res_lo_we, res_hi_we, sp_dec}, 32'd0);
      @(negedge clk);
      chk({rq, " pulse"}, {31'd0, done}, 32'd0);
      return;
    end
    if (disturb) begin start = 1'b1; op_sel = op ^ 3'd1; end
    chk("R8 early1", {31'd0, done}, 32'd0);
    @(negedge clk);
    start = 1'b0; op_sel = 3'd0;
    chk("R8 early2", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R8 done", {31'd0, done}, 32'd1);
    case (op)
      3'd0: exp_res = l + r;
      3'd1: exp_res = l - r;
      default: exp_res = 32'd0;
    endcase
    if (op[1]) begin
      chk(disturb ? {rq, " R9"} : rq, {16'd0, res_lo}, {16'd0, cmp_word(l, r, op == 3'd2)});
      chk({rq, " we/spd"}, {28'd0, res_lo_we, res_hi_we, sp_dec}, {28'd0, 2'b10, 2'd3});
    end else begin
      chk(disturb ? {rq, " R9"} : rq, {res_hi, res_lo}, exp_res);
      chk({rq, " we/spd"}, {28'd0, res_lo_we, res_hi_we, sp_dec}, {28'd0, 2'b11, 2'd2});
    end
    @(negedge clk);
    chk("R8 pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog act=%0d exp=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done/we/spd", {28'd0, done, res_lo_we, res_hi_we, 1'b0}, 32'd0);
    chk("R1 spd", {30'd0, sp_dec}, 32'd0);
    chk("R1 res", {res_hi, res_lo}, 32'd0);
    rst_n = 1'b1;

    // directed corners
    apply(3'd0, 32'h0000_FFFF, 32'h0000_0001, 1'b0); // R3 carry
    apply(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0); // R2 wrap
    apply(3'd1, 32'h0001_0000, 32'h0000_0001, 1'b0); // R4 borrow
    apply(3'd1, 32'h0000_0000, 32'h0000_0001, 1'b0); // R4 wrap
    apply(3'd2, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0); // R5 min < max
    apply(3'd2, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0); // R5
    apply(3'd2, 32'h1234_5678, 32'h1234_5678, 1'b0); // R5 equal
    apply(3'd2, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0); // R5 -1 < 0
    apply(3'd3, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0); // R6
    apply(3'd3, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0); // R6
    apply(3'd3, 32'h0001_0000, 32'h0000_FFFF, 1'b0); // R6 low borrow
    apply(3'd3, 32'hABCD_0000, 32'hABCD_0000, 1'b0); // R6 equal
    for (int k = 4; k < 8; k++) apply(k[2:0], 32'h1111_2222, 32'h3333_4444, 1'b0); // R7
    apply(3'd0, 32'h1357_9BDF, 32'h0246_8ACE, 1'b1); // R9
    apply(3'd2, 32'h8000_0001, 32'h0000_0002, 1'b1); // R9

    // random stimulus
    for (int n = 0; n < 400; n++) begin
      a = $urandom();
      b = $urandom();
      case ($urandom_range(0, 4))
        0: b = a;
        1: b[31:16] = a[31:16];
        2: b[15:0] = a[15:0];
        default: ;
      endcase
      apply(3'($urandom_range(0, 3)), a, b, ($urandom_range(0, 7) == 0));
    end

    summary();
    $finish;
  end
endmodule